// File: doc/BRIEF.md
# Staged Forward Byte-Copy Sequencer

The block moves a run of bytes from a source address to a destination address in ascending address order. Software splits one copy into three commands: a setup stage, a bulk stage and a tail stage. Each command runs to completion on its own and ends with a one-cycle `done` pulse. The sequencer keeps three 64-bit values (destination, source, byte count) and a 4-bit condition-flag word. The setup stage writes the flag word, and the later stages read it.

Two register encodings are supported. In the offset encoding, the setup stage moves both pointers to the end of the region and stores the count as a negative number. Each request then addresses pointer plus count, and only the count climbs toward zero. In the pointer encoding, the pointers and the count keep their plain meaning and move together. The setup stage records which encoding is in use in the carry flag.

Each request moves at most one block. The memory side returns how many bytes it really moved. A short return stops the stage with `fault` set, and the three values then describe exactly the bytes that were completed. Reissuing the stage resumes the copy.

Top module: `fwd_copy_engine`

## Requirements
- R1: A setup command (`cmd_stage`=0) whose `cmd_size` has bit 63 set uses 0x7FFF_FFFF_FFFF_FFFF as the size before anything else is done.
- R2: A setup command with `cmd_alg_a`=1 applies the offset encoding. The saturated size S is added to destination and source, the count becomes 0−S, and the flag word (bit3 N, bit2 Z, bit1 C, bit0 V) becomes 4'b0000.
- R3: A setup command with `cmd_alg_a`=0 applies the pointer encoding. The values stay plain and the flag word becomes 4'b0010.
- R4: In the offset encoding, a request reads at source+count and writes at destination+count. A completed block of n bytes adds n to the count and leaves both pointers unchanged.
- R5: In the pointer encoding, a request reads at source and writes at destination. A completed block of n bytes adds n to both pointers and subtracts n from the count.
- R6: Let rem be the bytes left (−count in the offset encoding, count otherwise). The stage moves min(rem,16) bytes for setup (0), min(rem rounded down to a multiple of 16, 64) for bulk (1), and rem for tail (2). Each request has length min(16, stage bytes left) and is never zero. A stage with nothing to move issues no request.
- R7: When `mem_copied` is below `mem_len`, the values are updated by `mem_copied` bytes only, the stage stops, and `done` and `fault` pulse together.
- R8: A tail command that ends without a fault leaves the count at zero.
- R9: Only setup commands change the flag word. Bulk and tail commands select the offset encoding when flag bit 1 (C) is 0 and the pointer encoding when it is 1.
- R10: Addresses only ascend. Each request after a complete block starts exactly `mem_len` bytes above the previous one, and a pending request holds its fields until `mem_ack`.
- R11: `mem_hints` repeats `cmd_hints` of the running command unchanged: bit3 reads non-temporal, bit2 writes non-temporal, bit1 reads unprivileged, bit0 writes unprivileged.
- R12: Each accepted command ends with `done` high for exactly one cycle. A command that arrives while `busy` is high, or that has `cmd_stage`=3, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Starts a stage when idle |
| cmd_stage | input | 2 | 0 setup, 1 bulk, 2 tail |
| cmd_alg_a | input | 1 | Setup only: 1 selects the offset encoding |
| cmd_hints | input | 4 | Request attribute bits |
| cmd_dst | input | 64 | Setup only: destination address |
| cmd_src | input | 64 | Setup only: source address |
| cmd_size | input | 64 | Setup only: byte count |
| busy | output | 1 | A stage is running |
| done | output | 1 | One-cycle end-of-stage pulse |
| fault | output | 1 | Stage ended on a short transfer |
| dst_out | output | 64 | Destination value |
| src_out | output | 64 | Source value |
| size_out | output | 64 | Count value |
| flags_out | output | 4 | Flag word {N,Z,C,V} |
| mem_req | output | 1 | Block request pending |
| mem_rd_addr | output | 64 | Block read address |
| mem_wr_addr | output | 64 | Block write address |
| mem_len | output | 5 | Block length in bytes |
| mem_hints | output | 4 | Request attributes |
| mem_ack | input | 1 | Request served this cycle |
| mem_copied | input | 5 | Bytes actually moved |

## Verification
Some properties are checked on every cycle: that a request never exceeds a block and is never empty, that a waiting request stays frozen, that consecutive complete blocks ascend by exactly their length, that flags change only on an accepted setup command, that a fault always comes with `done`, and that a clean tail leaves a zero count. Other behaviour only shows up in the bench scenarios. These are the split of bytes across the three stages, the saturation and encoding arithmetic, the exact values left after a short transfer, resumption after a fault, the carry-driven choice of encoding in later stages, and the rejection of commands while busy.

// File: rtl/fce_pkg.sv
package fce_pkg;
  typedef enum logic [1:0] {
    STG_PRO  = 2'd0,
    STG_MAIN = 2'd1,
    STG_EPI  = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PLAN = 2'd1,
    S_XFER = 2'd2
  } state_e;

  localparam logic [3:0] FLAGS_ALG_A = 4'b0000;
  localparam logic [3:0] FLAGS_ALG_B = 4'b0010;
  localparam int         CARRY_BIT   = 1;
endpackage

// File: rtl/fce_setup_enc.sv
module fce_setup_enc #(
  parameter int XLEN = 64
) (
  input  logic            alg_a,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] size_i,
  output logic [XLEN-1:0] dst_o,
  output logic [XLEN-1:0] src_o,
  output logic [XLEN-1:0] size_o,
  output logic [3:0]      flags_o
);
  localparam logic [XLEN-1:0] SAT_MAX = {1'b0, {(XLEN-1){1'b1}}};

  logic [XLEN-1:0] sat_size;

  always_comb begin
    sat_size = size_i[XLEN-1] ? SAT_MAX : size_i;
    if (alg_a) begin
      dst_o   = dst_i + sat_size;
      src_o   = src_i + sat_size;
      size_o  = '0 - sat_size;
      flags_o = fce_pkg::FLAGS_ALG_A;
    end else begin
      dst_o   = dst_i;
      src_o   = src_i;
      size_o  = sat_size;
      flags_o = fce_pkg::FLAGS_ALG_B;
    end
  end
endmodule

// File: rtl/fce_stage_plan.sv
module fce_stage_plan #(
  parameter int XLEN     = 64,
  parameter int BLK_MAX  = 16,
  parameter int HEAD_MAX = 16,
  parameter int MAIN_MAX = 64
) (
  input  fce_pkg::stage_e  stage,
  input  logic             alg_a,
  input  logic [XLEN-1:0]  size,
  output logic [XLEN-1:0]  stage_bytes
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(BLK_MAX - 1));
  localparam logic [XLEN-1:0] HEAD_LIM   = XLEN'(HEAD_MAX);
  localparam logic [XLEN-1:0] MAIN_LIM   = XLEN'(MAIN_MAX);

  logic [XLEN-1:0] rem;
  logic [XLEN-1:0] aligned;

  always_comb begin
    rem     = alg_a ? ('0 - size) : size;
    aligned = rem & ALIGN_MASK;
    unique case (stage)
      fce_pkg::STG_PRO:  stage_bytes = (rem < HEAD_LIM) ? rem : HEAD_LIM;
      fce_pkg::STG_MAIN: stage_bytes = (aligned < MAIN_LIM) ? aligned : MAIN_LIM;
      default:           stage_bytes = rem;
    endcase
  end
endmodule

// File: rtl/fce_blk_sizer.sv
module fce_blk_sizer #(
  parameter int XLEN    = 64,
  parameter int BLK_MAX = 16,
  parameter int LEN_W   = $clog2(BLK_MAX + 1)
) (
  input  logic [XLEN-1:0]  left,
  output logic [LEN_W-1:0] blk_len
);
  localparam logic [XLEN-1:0] BLK_LIM = XLEN'(BLK_MAX);

  always_comb begin
    if (left < BLK_LIM) blk_len = left[LEN_W-1:0];
    else                blk_len = LEN_W'(BLK_MAX);
  end
endmodule

// File: rtl/fwd_copy_engine.sv
module fwd_copy_engine #(
  parameter int XLEN     = 64,
  parameter int BLK_MAX  = 16,
  parameter int HEAD_MAX = 16,
  parameter int MAIN_MAX = 64,
  localparam int LEN_W   = $clog2(BLK_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_stage,
  input  logic             cmd_alg_a,
  input  logic [3:0]       cmd_hints,
  input  logic [XLEN-1:0]  cmd_dst,
  input  logic [XLEN-1:0]  cmd_src,
  input  logic [XLEN-1:0]  cmd_size,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [XLEN-1:0]  dst_out,
  output logic [XLEN-1:0]  src_out,
  output logic [XLEN-1:0]  size_out,
  output logic [3:0]       flags_out,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_rd_addr,
  output logic [XLEN-1:0]  mem_wr_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic [3:0]       mem_hints,
  input  logic             mem_ack,
  input  logic [LEN_W-1:0] mem_copied
);
  import fce_pkg::*;

  state_e          state_q, state_d;
  stage_e          stage_q, stage_d;
  logic [XLEN-1:0] dst_q, dst_d, src_q, src_d, size_q, size_d, left_q, left_d;
  logic [3:0]      flags_q, flags_d, hints_q, hints_d;
  logic            done_q, done_d, fault_q, fault_d;

  logic [XLEN-1:0] enc_dst, enc_src, enc_size, plan_bytes;
  logic [3:0]      enc_flags;
  logic [LEN_W-1:0] blk_len, step_n;
  logic            alg_a, cmd_take, short_xfer, reg_en;

  fce_setup_enc #(.XLEN(XLEN)) u_enc (
    .alg_a  (cmd_alg_a),
    .dst_i  (cmd_dst),
    .src_i  (cmd_src),
    .size_i (cmd_size),
    .dst_o  (enc_dst),
    .src_o  (enc_src),
    .size_o (enc_size),
    .flags_o(enc_flags)
  );

  fce_stage_plan #(
    .XLEN(XLEN), .BLK_MAX(BLK_MAX), .HEAD_MAX(HEAD_MAX), .MAIN_MAX(MAIN_MAX)
  ) u_plan (
    .stage      (stage_q),
    .alg_a      (alg_a),
    .size       (size_q),
    .stage_bytes(plan_bytes)
  );

  fce_blk_sizer #(.XLEN(XLEN), .BLK_MAX(BLK_MAX), .LEN_W(LEN_W)) u_sizer (
    .left   (left_q),
    .blk_len(blk_len)
  );

  // Encoding in use follows the carry flag written at setup.
  assign alg_a      = ~flags_q[CARRY_BIT];
  assign cmd_take   = (state_q == S_IDLE) && cmd_valid && (cmd_stage != 2'd3);
  assign short_xfer = (mem_copied < blk_len);
  assign step_n     = short_xfer ? mem_copied : blk_len;
  assign reg_en     = (state_q != S_IDLE) || cmd_take || done_q;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    dst_d   = dst_q;
    src_d   = src_q;
    size_d  = size_q;
    left_d  = left_q;
    flags_d = flags_q;
    hints_d = hints_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_take) begin
          stage_d = stage_e'(cmd_stage);
          hints_d = cmd_hints;
          if (cmd_stage == STG_PRO) begin
            dst_d   = enc_dst;
            src_d   = enc_src;
            size_d  = enc_size;
            flags_d = enc_flags;
          end
          state_d = S_PLAN;
        end
      end
      S_PLAN: begin
        left_d  = plan_bytes;
        state_d = S_XFER;
      end
      S_XFER: begin
        if (left_q == '0) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (mem_ack) begin
          if (alg_a) begin
            size_d = size_q + XLEN'(step_n);
          end else begin
            dst_d  = dst_q + XLEN'(step_n);
            src_d  = src_q + XLEN'(step_n);
            size_d = size_q - XLEN'(step_n);
          end
          left_d = left_q - XLEN'(step_n);
          if (short_xfer) begin
            done_d  = 1'b1;
            fault_d = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stage_q <= STG_PRO;
      dst_q   <= '0;
      src_q   <= '0;
      size_q  <= '0;
      left_q  <= '0;
      flags_q <= '0;
      hints_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      stage_q <= stage_d;
      dst_q   <= dst_d;
      src_q   <= src_d;
      size_q  <= size_d;
      left_q  <= left_d;
      flags_q <= flags_d;
      hints_q <= hints_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign fault       = fault_q;
  assign dst_out     = dst_q;
  assign src_out     = src_q;
  assign size_out    = size_q;
  assign flags_out   = flags_q;
  assign mem_req     = (state_q == S_XFER) && (left_q != '0);
  assign mem_rd_addr = alg_a ? (src_q + size_q) : src_q;
  assign mem_wr_addr = alg_a ? (dst_q + size_q) : dst_q;
  assign mem_len     = blk_len;
  assign mem_hints   = hints_q;
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int XLEN    = 64,
  parameter int BLK_MAX = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_stage,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [XLEN-1:0]  size_out,
  input logic [3:0]       flags_out,
  input logic             mem_req,
  input logic [XLEN-1:0]  mem_rd_addr,
  input logic [XLEN-1:0]  mem_wr_addr,
  input logic [LEN_W-1:0] mem_len,
  input logic             mem_ack,
  input logic [LEN_W-1:0] mem_copied,
  input fce_pkg::stage_e  stage
);
  p_blk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= LEN_W'(BLK_MAX)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_rd_addr)
                              && $stable(mem_wr_addr) && $stable(mem_len));

  p_fwd_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && (mem_copied >= mem_len)) |=>
      (!mem_req || ((mem_rd_addr == $past(mem_rd_addr) + XLEN'($past(mem_len)))
                 && (mem_wr_addr == $past(mem_wr_addr) + XLEN'($past(mem_len))))));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !busy && (cmd_stage == 2'd0)) |=> $stable(flags_out));

  p_fault_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && (stage == fce_pkg::STG_EPI)) |-> (size_out == '0));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
endmodule

bind fwd_copy_engine fce_checker #(.XLEN(XLEN), .BLK_MAX(BLK_MAX), .LEN_W(LEN_W)) u_fce_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_stage  (cmd_stage),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .size_out   (size_out),
  .flags_out  (flags_out),
  .mem_req    (mem_req),
  .mem_rd_addr(mem_rd_addr),
  .mem_wr_addr(mem_wr_addr),
  .mem_len    (mem_len),
  .mem_ack    (mem_ack),
  .mem_copied (mem_copied),
  .stage      (stage_q)
);

// File: tb/fwd_copy_engine_bench.sv
module fwd_copy_engine_bench;
  localparam logic [63:0] SAT = 64'h7FFF_FFFF_FFFF_FFFF;

  typedef struct {
    logic [63:0] rd;
    logic [63:0] wr;
    int          len;
    int          copied;
    logic [3:0]  hints;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_stage;
  logic        cmd_alg_a;
  logic [3:0]  cmd_hints;
  logic [63:0] cmd_dst, cmd_src, cmd_size;
  logic        busy, done, fault;
  logic [63:0] dst_out, src_out, size_out;
  logic [3:0]  flags_out;
  logic        mem_req;
  logic [63:0] mem_rd_addr, mem_wr_addr;
  logic [4:0]  mem_len;
  logic [3:0]  mem_hints;
  logic        mem_ack;
  logic [4:0]  mem_copied;

  int ntests = 0;
  int nfail  = 0;
  item_t exp_q[$];
  item_t cur;

  logic [63:0] m_dst, m_src, m_size;
  logic [3:0]  m_flags;

  always #4 clk = ~clk;

  fwd_copy_engine u_fwd_copy_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_stage(cmd_stage),
    .cmd_alg_a(cmd_alg_a), .cmd_hints(cmd_hints), .cmd_dst(cmd_dst),
    .cmd_src(cmd_src), .cmd_size(cmd_size), .busy(busy), .done(done),
    .fault(fault), .dst_out(dst_out), .src_out(src_out), .size_out(size_out),
    .flags_out(flags_out), .mem_req(mem_req), .mem_rd_addr(mem_rd_addr),
    .mem_wr_addr(mem_wr_addr), .mem_len(mem_len), .mem_hints(mem_hints),
    .mem_ack(mem_ack), .mem_copied(mem_copied)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: serves each request and compares it against the queue head.
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected request", mem_rd_addr, 64'h0);
        mem_copied = mem_len;
      end else begin
        cur = exp_q.pop_front();
        chk(mem_rd_addr == cur.rd, "R4/R5 read address", mem_rd_addr, cur.rd);
        chk(mem_wr_addr == cur.wr, "R4/R5 write address", mem_wr_addr, cur.wr);
        chk(64'(mem_len) == 64'(cur.len), "R6 block length", 64'(mem_len), 64'(cur.len));
        chk(mem_hints == cur.hints, "R11 hints", 64'(mem_hints), 64'(cur.hints));
        mem_copied = 5'(cur.copied);
      end
      mem_ack = 1'b1;
    end else begin
      mem_ack = 1'b0;
    end
  end

  // Driver: builds the expected block list from the requirements, then runs the stage.
  task automatic run_stage(input int stg, input bit alg, input logic [3:0] hints,
                           input logic [63:0] d, input logic [63:0] s,
                           input logic [63:0] z, input int fault_idx,
                           input int fault_cnt, input bit poke_busy);
    logic [63:0] rem, left, sz, fl_before;
    bit   a, exp_fault;
    int   i, b, c;
    item_t it;
    fl_before = 64'(m_flags);
    if (stg == 0) begin
      sz = z[63] ? SAT : z;                          // R1
      if (alg) begin                                 // R2
        m_dst = d + sz; m_src = s + sz; m_size = 64'h0 - sz; m_flags = 4'b0000;
      end else begin                                 // R3
        m_dst = d; m_src = s; m_size = sz; m_flags = 4'b0010;
      end
    end
    a   = ~m_flags[1];                               // R9
    rem = a ? (64'h0 - m_size) : m_size;
    if (stg == 0)      left = (rem < 16) ? rem : 64'd16;
    else if (stg == 1) left = ((rem & ~64'hF) < 64) ? (rem & ~64'hF) : 64'd64;
    else               left = rem;
    exp_fault = 1'b0;
    i = 0;
    while (left != 0 && !exp_fault) begin
      b = (left < 16) ? int'(left) : 16;
      c = (i == fault_idx) ? fault_cnt : b;
      it.rd = a ? m_src + m_size : m_src;
      it.wr = a ? m_dst + m_size : m_dst;
      it.len = b; it.copied = c; it.hints = hints;
      exp_q.push_back(it);
      if (a) m_size = m_size + 64'(c);
      else begin m_dst = m_dst + 64'(c); m_src = m_src + 64'(c); m_size = m_size - 64'(c); end
      left = left - 64'(c);
      if (c < b) exp_fault = 1'b1;
      i++;
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_stage = 2'(stg); cmd_alg_a = alg; cmd_hints = hints;
    cmd_dst = d; cmd_src = s; cmd_size = z;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int n;
      for (n = 0; n < 3000; n++) begin
        @(negedge clk);
        if (poke_busy && n == 1) begin               // R12 command while busy
          cmd_valid = 1'b1; cmd_stage = 2'd0; cmd_alg_a = ~alg; cmd_size = 64'd7;
          cmd_dst = 64'hDEAD_0000; cmd_src = 64'hBEEF_0000;
        end else if (poke_busy && n == 2) cmd_valid = 1'b0;
        if (done) break;
      end
      if (n == 3000) chk(1'b0, "R12 stage never finished", 64'h0, 64'h1);
    end
    chk(fault == exp_fault, "R7 fault flag", 64'(fault), 64'(exp_fault));
    chk(exp_q.size() == 0, "R6 all blocks issued", 64'(exp_q.size()), 64'h0);
    chk(dst_out == m_dst, "R4/R5/R7 destination", dst_out, m_dst);
    chk(src_out == m_src, "R4/R5/R7 source", src_out, m_src);
    chk(size_out == m_size, "R4/R5/R7 count", size_out, m_size);
    chk(flags_out == m_flags, "R9 flags", 64'(flags_out), 64'(m_flags));
    if (stg != 0) chk(64'(flags_out) == fl_before, "R9 flags unchanged", 64'(flags_out), fl_before);
    if (stg == 2 && !exp_fault) chk(size_out == 0, "R8 tail leaves zero", size_out, 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", 64'(done), 64'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_stage = 2'd0; cmd_alg_a = 1'b0;
    cmd_hints = 4'h0; cmd_dst = '0; cmd_src = '0; cmd_size = '0;
    mem_ack = 1'b0; mem_copied = '0;
    m_dst = '0; m_src = '0; m_size = '0; m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R12 reset idle",
        {61'h0, busy, done, mem_req}, 64'h0);
    chk(flags_out == 4'h0 && size_out == 0, "R9 reset values", 64'(flags_out), 64'h0);

    // Pointer encoding, full three-stage flow; bulk issued with a stray command.
    run_stage(0, 1'b0, 4'b1010, 64'h1000, 64'h2000, 64'd100, -1, 0, 0);
    run_stage(1, 1'b0, 4'b1010, 0, 0, 0, -1, 0, 1);
    run_stage(2, 1'b0, 4'b0101, 0, 0, 0, -1, 0, 0);

    // Offset encoding, full flow.
    run_stage(0, 1'b1, 4'b0001, 64'h3000, 64'h4000, 64'd40, -1, 0, 0);
    run_stage(1, 1'b1, 4'b0010, 0, 0, 0, -1, 0, 0);
    run_stage(2, 1'b1, 4'b1100, 0, 0, 0, -1, 0, 0);

    // Saturation in both encodings (R1).
    run_stage(0, 1'b1, 4'h0, 64'h5000, 64'h6000, 64'h8000_0000_0000_0005, -1, 0, 0);
    run_stage(0, 1'b0, 4'h0, 64'h5000, 64'h6000, 64'h8000_0000_0000_0000, -1, 0, 0);

    // Short transfer in bulk stage, then resume (R7).
    run_stage(0, 1'b0, 4'h3, 64'h7000, 64'h8000, 64'd50, -1, 0, 0);
    run_stage(1, 1'b0, 4'h3, 0, 0, 0, 1, 3, 0);
    run_stage(1, 1'b0, 4'h3, 0, 0, 0, -1, 0, 0);
    run_stage(2, 1'b0, 4'h3, 0, 0, 0, -1, 0, 0);

    // Offset encoding with a zero-byte return in setup, then finish.
    run_stage(0, 1'b1, 4'h8, 64'h9000, 64'hA000, 64'd21, 0, 0, 0);
    run_stage(2, 1'b1, 4'h8, 0, 0, 0, -1, 0, 0);

    // Empty copy and small setup.
    run_stage(0, 1'b0, 4'h0, 64'hB000, 64'hC000, 64'd0, -1, 0, 0);
    run_stage(0, 1'b0, 4'h0, 64'hB000, 64'hC000, 64'd5, -1, 0, 0);

    // Reserved stage code is ignored (R12).
    @(negedge clk);
    cmd_valid = 1'b1; cmd_stage = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R12 reserved code ignored", 64'(busy), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule